// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block computes, for one load or store request per clock, the memory address that the access drives and the value a base register receives when the addressing form updates it. A request carries a base value, an offset that is either a zero-extended immediate or an index register shifted left by a 5-bit amount, an add/subtract direction, one of three indexing forms, and the transfer size and signedness.

The three indexing forms share one adder and differ only in output steering. In plain offset form the adjusted address is used and nothing is written back. In pre-update form the adjusted address is both used and written back. In post-update form the untouched base is used and the adjusted value is written back. A misalignment flag marks word accesses whose two low address bits are not zero and halfword accesses with an odd address.

Every request is accepted. Its result, with size and signedness passed along for the data path, appears on registered outputs in the following cycle, qualified by `valid_o`.

Top module: `load_store_agen`

## Requirements
- R1: After reset `valid_o`, `wb_en_o` and `misalign_o` are 0.
- R2: Offset form (`mode_i`=0): `addr_o` is base adjusted by the offset, and `wb_en_o` is 0.
- R3: Pre-update form (`mode_i`=1): `addr_o` and `wb_data_o` both equal base adjusted by the offset, and `wb_en_o` is 1.
- R4: Post-update form (`mode_i`=2): `addr_o` equals the unmodified base, `wb_data_o` equals base adjusted by the offset, and `wb_en_o` is 1.
- R5: With `off_sel_i`=0 the offset is `imm_i` zero-extended to 32 bits, and `shamt_i` and `index_i` have no effect.
- R6: With `off_sel_i`=1 the offset is `index_i` shifted left by `shamt_i` (0..31), and bits moved past bit 31 are lost.
- R7: `sub_i`=0 adds the offset to the base and `sub_i`=1 subtracts it, both modulo 2^32.
- R8: `misalign_o` is 1 when `size_i` is 2 (word) or 3 (treated as word) and `addr_o[1:0]` is not 0, or when `size_i` is 1 (halfword) and `addr_o[0]` is 1. It is never 1 when `size_i` is 0 (byte).
- R9: Results appear one cycle after a request with `req_valid_i`=1, with `valid_o`=1. After a cycle with no request, `valid_o`, `wb_en_o` and `misalign_o` are 0.
- R10: The reserved mode code 3 behaves as the offset form: the adjusted address is used and there is no writeback.
- R11: `size_o` and `signed_o` repeat the `size_i` and `signed_i` of the request that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| base_i | input | 32 | Base register value |
| off_sel_i | input | 1 | 0: immediate offset, 1: shifted index offset |
| imm_i | input | 12 | Immediate offset, zero-extended |
| index_i | input | 32 | Index register value |
| shamt_i | input | 5 | Left shift applied to the index |
| sub_i | input | 1 | 0: add offset, 1: subtract offset |
| mode_i | input | 2 | 0 offset, 1 pre-update, 2 post-update, 3 reserved (as 0) |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 word |
| signed_i | input | 1 | Signed transfer |
| valid_o | output | 1 | Result present |
| addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base writeback enable |
| wb_data_o | output | 32 | Base writeback value |
| misalign_o | output | 1 | Access not aligned to its size |
| size_o | output | 2 | Transfer size of the result |
| signed_o | output | 1 | Signedness of the result |

## Verification
The assertions take all request inputs to be known (not X) in every cycle after reset, since they compare the registered results against the previous cycle's base and sizes. The stimulus drives every input on every cycle, idle or not, drawn from a fixed-seed random source, so this holds throughout. Random draws cover all four mode codes, all four size codes, both offset sources and both directions. Directed vectors add wrap-around at the 32-bit boundary, shifts of 0 and 31, and low address bits chosen to trip or avoid the misalignment flag.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  typedef enum logic [1:0] {
    MODE_OFFS = 2'd0,
    MODE_PRE  = 2'd1,
    MODE_POST = 2'd2,
    MODE_RSVD = 2'd3
  } idx_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/lsag_offset_gen.sv
module lsag_offset_gen #(
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  localparam int SH_W = $clog2(DW)
) (
  input  logic             off_sel_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [DW-1:0]    index_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [DW-1:0]    offset_o
);
  logic [DW-1:0] imm_ext;
  logic [DW-1:0] idx_shl;

  generate
    if (DW > IMM_W) begin : g_zext
      assign imm_ext = {{(DW-IMM_W){1'b0}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DW-1:0];
    end
  endgenerate

  // bits beyond the top are dropped by the fixed-width shift
  assign idx_shl  = index_i << shamt_i;
  assign offset_o = off_sel_i ? idx_shl : imm_ext;
endmodule

// File: rtl/lsag_addsub.sv
module lsag_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] offset_i,
  input  logic          sub_i,
  output logic [DW-1:0] result_o
);
  logic [DW-1:0] opnd;
  assign opnd     = sub_i ? ~offset_i : offset_i;
  assign result_o = base_i + opnd + {{(DW-1){1'b0}}, sub_i};
endmodule

// File: rtl/lsag_align_chk.sv
module lsag_align_chk #(
  parameter int DW = 32
) (
  input  lsag_pkg::xfer_size_e size_i,
  input  logic [DW-1:0]        addr_i,
  output logic                 misalign_o
);
  import lsag_pkg::*;
  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = addr_i[0];
      default: misalign_o = |addr_i[1:0];
    endcase
  end
endmodule

// File: rtl/load_store_agen.sv
module load_store_agen #(
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  localparam int SH_W = $clog2(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [DW-1:0]    base_i,
  input  logic             off_sel_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [DW-1:0]    index_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             sub_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       size_i,
  input  logic             signed_i,
  output logic             valid_o,
  output logic [DW-1:0]    addr_o,
  output logic             wb_en_o,
  output logic [DW-1:0]    wb_data_o,
  output logic             misalign_o,
  output logic [1:0]       size_o,
  output logic             signed_o
);
  import lsag_pkg::*;

  idx_mode_e  mode;
  xfer_size_e size;
  assign mode = idx_mode_e'(mode_i);
  assign size = xfer_size_e'(size_i);

  logic [DW-1:0] offset, adj, ea_d;
  logic          wb_d, mis_d;

  lsag_offset_gen #(.DW(DW), .IMM_W(IMM_W)) u_offset_gen (
    .off_sel_i (off_sel_i),
    .imm_i     (imm_i),
    .index_i   (index_i),
    .shamt_i   (shamt_i),
    .offset_o  (offset)
  );

  lsag_addsub #(.DW(DW)) u_addsub (
    .base_i   (base_i),
    .offset_i (offset),
    .sub_i    (sub_i),
    .result_o (adj)
  );

  always_comb begin
    unique case (mode)
      MODE_PRE:  begin ea_d = adj;    wb_d = 1'b1; end
      MODE_POST: begin ea_d = base_i; wb_d = 1'b1; end
      default:   begin ea_d = adj;    wb_d = 1'b0; end
    endcase
  end

  lsag_align_chk #(.DW(DW)) u_align_chk (
    .size_i     (size),
    .addr_i     (ea_d),
    .misalign_o (mis_d)
  );

  idx_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      wb_en_o    <= 1'b0;
      misalign_o <= 1'b0;
      addr_o     <= '0;
      wb_data_o  <= '0;
      size_o     <= '0;
      signed_o   <= 1'b0;
      mode_q     <= MODE_OFFS;
    end else begin
      valid_o    <= req_valid_i;
      wb_en_o    <= req_valid_i & wb_d;
      misalign_o <= req_valid_i & mis_d;
      if (req_valid_i) begin
        addr_o    <= ea_d;
        wb_data_o <= adj;
        size_o    <= size_i;
        signed_o  <= signed_i;
        mode_q    <= mode;
      end
    end
  end

  // R9: qualified outputs only with a result present
  assert_wb_needs_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o || misalign_o) |-> valid_o);

  // R3: pre-update uses and writes back the same value
  assert_pre_same_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == MODE_PRE) |-> (wb_en_o && wb_data_o == addr_o));

  // R4: post-update drives the base of the accepted request
  assert_post_base_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode == MODE_POST) |=> (addr_o == $past(base_i) && wb_en_o));

  // R2 / R10: offset and reserved forms never write back
  assert_offs_no_wb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (mode == MODE_OFFS || mode == MODE_RSVD)) |=> !wb_en_o);

  // R8: byte accesses are never flagged
  assert_byte_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && size_o == 2'd0) |-> !misalign_o);

  // R7: adder relation against its operands
  assert_addsub_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (sub_i ? (adj + offset == base_i) : (adj - offset == base_i)));
endmodule

// File: tb/load_store_agen_bench.sv
module load_store_agen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] base_i = '0;
  logic        off_sel_i = 1'b0;
  logic [11:0] imm_i = '0;
  logic [31:0] index_i = '0;
  logic [4:0]  shamt_i = '0;
  logic        sub_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  size_i = '0;
  logic        signed_i = 1'b0;
  logic        valid_o, wb_en_o, misalign_o, signed_o;
  logic [31:0] addr_o, wb_data_o;
  logic [1:0]  size_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  load_store_agen u_load_store_agen (
    .clk_i, .rst_ni, .req_valid_i, .base_i, .off_sel_i, .imm_i, .index_i,
    .shamt_i, .sub_i, .mode_i, .size_i, .signed_i, .valid_o, .addr_o,
    .wb_en_o, .wb_data_o, .misalign_o, .size_o, .signed_o
  );

  // expected state for the request in flight
  bit          p_req;
  logic [31:0] e_addr, e_wbd;
  bit          e_wb, e_mis, e_sgn;
  logic [1:0]  e_sz;
  string       e_tag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] offset_of(bit sel, logic [11:0] im, logic [31:0] ix, logic [4:0] sh);
    return sel ? (ix << sh) : {20'd0, im};
  endfunction

  task automatic predict();
    logic [31:0] off, adj;
    off = offset_of(off_sel_i, imm_i, index_i, shamt_i);
    adj = sub_i ? base_i - off : base_i + off;
    p_req = req_valid_i;
    e_sz  = size_i;
    e_sgn = signed_i;
    case (mode_i)
      2'd1: begin e_addr = adj;    e_wb = 1; e_tag = "R3"; end
      2'd2: begin e_addr = base_i; e_wb = 1; e_tag = "R4"; end
      2'd3: begin e_addr = adj;    e_wb = 0; e_tag = "R10"; end
      default: begin e_addr = adj; e_wb = 0; e_tag = "R2"; end
    endcase
    e_wbd = adj;
    if (size_i == 2'd0)      e_mis = 0;
    else if (size_i == 2'd1) e_mis = e_addr[0];
    else                     e_mis = e_addr[1:0] != 2'b00;
    if (off_sel_i) e_tag = {e_tag, "/R6/R7"}; else e_tag = {e_tag, "/R5/R7"};
  endtask

  task automatic verify();
    if (!p_req) begin
      chk("R9 idle valid", {31'd0, valid_o}, 32'd0);
      chk("R9 idle wb_en", {31'd0, wb_en_o}, 32'd0);
      chk("R9 idle misalign", {31'd0, misalign_o}, 32'd0);
      return;
    end
    chk("R9 valid", {31'd0, valid_o}, 32'd1);
    chk({e_tag, " addr"}, addr_o, e_addr);
    chk({e_tag, " wb_en"}, {31'd0, wb_en_o}, {31'd0, e_wb});
    if (e_wb) chk({e_tag, " wb_data"}, wb_data_o, e_wbd);
    chk("R8 misalign", {31'd0, misalign_o}, {31'd0, e_mis});
    chk("R11 size", {30'd0, size_o}, {30'd0, e_sz});
    chk("R11 signed", {31'd0, signed_o}, {31'd0, e_sgn});
  endtask

  // drive at negedge, check previous request at the following negedge
  task automatic step(bit v, logic [31:0] b, bit sel, logic [11:0] im, logic [31:0] ix,
                      logic [4:0] sh, bit sb, logic [1:0] md, logic [1:0] sz, bit sg);
    req_valid_i = v; base_i = b; off_sel_i = sel; imm_i = im; index_i = ix;
    shamt_i = sh; sub_i = sb; mode_i = md; size_i = sz; signed_i = sg;
    predict();
    @(negedge clk_i);
    verify();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    int unsigned sd;
    sd = $urandom(32'h5eed_0042);
    repeat (2) @(negedge clk_i);
    // R1: reset state
    chk("R1 valid", {31'd0, valid_o}, 32'd0);
    chk("R1 wb_en", {31'd0, wb_en_o}, 32'd0);
    chk("R1 misalign", {31'd0, misalign_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed: R2 offset, imm add
    step(1, 32'h0000_1000, 0, 12'h004, 32'hFFFF_FFFF, 5'd31, 0, 2'd0, 2'd2, 0);
    // R3 pre, index shifted by 2, subtract
    step(1, 32'h0000_2000, 1, 12'hFFF, 32'h0000_0003, 5'd2, 1, 2'd1, 2'd2, 1);
    // R4 post, unaligned base word -> flag on base
    step(1, 32'h0000_3002, 0, 12'h010, 32'h0, 5'd0, 0, 2'd2, 2'd2, 0);
    // R10 reserved mode
    step(1, 32'h0000_4000, 0, 12'h001, 32'h0, 5'd0, 0, 2'd3, 2'd1, 1);
    // R6 shift 31 drops upper bits
    step(1, 32'h0000_0000, 1, 12'h0, 32'h0000_0003, 5'd31, 0, 2'd0, 2'd0, 0);
    // R6 shift 0
    step(1, 32'h1111_1110, 1, 12'h0, 32'h0000_0001, 5'd0, 0, 2'd0, 2'd1, 0);
    // R7 wrap-around both ways
    step(1, 32'hFFFF_FFFE, 0, 12'h004, 32'h0, 5'd0, 0, 2'd1, 2'd2, 0);
    step(1, 32'h0000_0001, 0, 12'h003, 32'h0, 5'd0, 1, 2'd1, 2'd1, 0);
    // R8 halfword odd, byte odd, size 3 as word
    step(1, 32'h0000_0101, 0, 12'h0, 32'h0, 5'd0, 0, 2'd0, 2'd1, 1);
    step(1, 32'h0000_0103, 0, 12'h0, 32'h0, 5'd0, 0, 2'd0, 2'd0, 1);
    step(1, 32'h0000_0102, 0, 12'h0, 32'h0, 5'd0, 0, 2'd0, 2'd3, 0);
    // R5 immediate: index and shift ignored
    step(1, 32'h0000_8000, 0, 12'h800, 32'hDEAD_BEEF, 5'd7, 0, 2'd1, 2'd2, 0);
    // R9 idle cycle
    step(0, 32'h0000_0002, 1, 12'h0, 32'h1, 5'd1, 0, 2'd1, 2'd2, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] b;
      b = $urandom;
      if ($urandom_range(3) == 0) b[1:0] = 2'b00;
      step($urandom_range(7) != 0, b, 1'($urandom), 12'($urandom), $urandom,
           5'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule